// File: doc/BRIEF.md
# OTG Plug-Type Detector and USB Control Register

This block samples the asynchronous OTG identification pin of a USB port and tells software when the attached plug changes between the host and peripheral type. The pin idles high through an internal pull-up, and high means peripheral mode. Plugging or unplugging a host-side (A) plug pulls the level low or lets it go back high. Either change sets a sticky transition flag, which can raise an interrupt request. A peripheral-side (B) plug leaves the pin high, so it is never flagged.

The block also holds the general USB control register that drives the enable, register-bank select, clock-freeze and OTG pad-enable lines of the neighbouring controller. Software reaches it over a simple register bus with a combinational read path. A status register shows the synchronized pin level. An interrupt register holds the transition flag. Detection, the flag and the interrupt path keep working while the controller enable is 0. The pad-enable bit can also be written while the controller is disabled.

Top module: `otg_id_ctl`

## Requirements
- R1: After reset, the control register (address 0xE1) and the interrupt register (address 0xE3) read 0x00, `irq` is 0, and with the pin held high the status register (address 0xE2) reads 0x02.
- R2: The control register uses this bit layout: bit 7 controller enable, bit 6 host register-bank select, bit 5 clock freeze, bit 4 OTG pad enable, bit 1 ID-transition interrupt enable, bit 0 VBUS-transition interrupt enable. A write loads the register, and a read returns what was stored.
- R3: Control bits 3 and 2 always read 0, whatever is written to them.
- R4: A control write with bit 7 = 0 forces the host-select and clock-freeze bits to 0. Bits 4, 1 and 0 still take the written values.
- R5: `usbEnable`, `hostBank`, `clkFreeze` and `padEnable` equal control bits 7, 6, 5 and 4. `coreClkEn` is high only when bit 7 = 1 and bit 5 = 0.
- R6: Status bit 1 shows the pin level two clock edges after a change, through a two-flop synchronizer. All other status bits read 0.
- R7: A rising or a falling pin change sets interrupt bit 1 on the third clock edge after the change. A pin that stays high never sets it.
- R8: The flag is sticky. Writing the interrupt register with bit 1 = 0 clears it. Writing it with bit 1 = 1 leaves the flag as it was.
- R9: When a pin change and a clearing write reach the flag on the same edge, the flag ends up set.
- R10: `irq` is 1 exactly when the flag is set and control bit 1 is 1.
- R11: Detection, the flag and `irq` behave the same while control bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idPin | input | 1 | Asynchronous OTG identification pin |
| regAddr | input | 8 | Register address |
| regWe | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| irq | output | 1 | ID-transition interrupt request |
| usbEnable | output | 1 | Controller enable; 0 holds the controller and transceiver in reset |
| hostBank | output | 1 | Host register bank selected |
| clkFreeze | output | 1 | Controller clock freeze |
| padEnable | output | 1 | OTG pad enable |
| coreClkEn | output | 1 | Controller clock enable |

## Verification
Register reads are combinational, so the bench settles the address on the falling edge and compares a moment later. A control write appears on the outputs right after the rising edge that captures it. After a pin change, the status level is checked after exactly two rising edges and the flag after exactly three. The bench also checks that the flag is still 0 after two edges, so the latency is pinned in both directions. For the set-versus-clear race, the clearing write is placed so that it lands on the same edge as the flag set.

// File: rtl/otg_id_pkg.sv
package otg_id_pkg;

  localparam int DATA_W = 8;

  // control register field positions
  localparam int CTL_EN_BIT   = 7;
  localparam int CTL_HOST_BIT = 6;
  localparam int CTL_FRZ_BIT  = 5;
  localparam int CTL_PAD_BIT  = 4;
  localparam int CTL_IDIE_BIT = 1;
  localparam int CTL_VBIE_BIT = 0;

  // bit 1 of both the status and the interrupt registers
  localparam int ID_BIT = 1;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CTL  = 2'd1,
    RD_STAT = 2'd2,
    RD_INT  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   ctlWr;
    logic   flagClr;
    rdSel_e rdSel;
  } busStrobe_t;

  typedef struct packed {
    logic       en;
    logic       host;
    logic       frz;
    logic       pad;
    logic [1:0] rsv;
    logic       idIe;
    logic       vbIe;
  } ctlReg_t;

endpackage

// File: rtl/otg_id_regctl.sv
module otg_id_regctl
  import otg_id_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CTL_ADDR  = 'hE1,
  parameter int STAT_ADDR = 'hE2,
  parameter int INT_ADDR  = 'hE3
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output busStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] CtlA  = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] IntA  = ADDR_W'(INT_ADDR);

  logic hitCtl, hitStat, hitInt;

  assign hitCtl  = (regAddr == CtlA);
  assign hitStat = (regAddr == StatA);
  assign hitInt  = (regAddr == IntA);

  always_comb begin
    strobe         = '0;
    strobe.ctlWr   = regWe && hitCtl;
    // writing 0 to the flag bit clears it; writing 1 does nothing
    strobe.flagClr = regWe && hitInt && !regWdata[ID_BIT];
    if (hitCtl)       strobe.rdSel = RD_CTL;
    else if (hitStat) strobe.rdSel = RD_STAT;
    else if (hitInt)  strobe.rdSel = RD_INT;
    else              strobe.rdSel = RD_NONE;
  end

endmodule

// File: rtl/otg_id_datapath.sv
module otg_id_datapath
  import otg_id_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idPin,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output ctlReg_t           ctlQ,
  output logic              idLevel,
  output logic              idFlag,
  output logic              irq
);

  localparam int LastStage = SYNC_STAGES - 1;

  // synchronizer chain, preloaded high (= no plug)
  logic [SYNC_STAGES-1:0] syncQ;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b1;
        else       syncQ[0] <= idPin;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b1;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  assign idLevel = syncQ[LastStage];

  // edge detection on the synchronized level
  logic idPrev;
  logic idEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idPrev <= 1'b1;
    else       idPrev <= idLevel;
  end

  assign idEdge = idLevel ^ idPrev;

  // sticky flag: a new edge wins over a clearing write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               idFlag <= 1'b0;
    else if (idEdge)         idFlag <= 1'b1;
    else if (strobe.flagClr) idFlag <= 1'b0;
  end

  // control register
  ctlReg_t wrVal;

  always_comb begin
    wrVal      = ctlReg_t'(regWdata);
    wrVal.rsv  = 2'b00;
    // with the enable low, the bank select and the freeze stay at reset
    wrVal.host = regWdata[CTL_HOST_BIT] & regWdata[CTL_EN_BIT];
    wrVal.frz  = regWdata[CTL_FRZ_BIT] & regWdata[CTL_EN_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ctlQ <= '0;
    else if (strobe.ctlWr) ctlQ <= wrVal;
  end

  assign irq = idFlag & ctlQ.idIe;

  // read mux
  always_comb begin
    regRdata = '0;
    unique case (strobe.rdSel)
      RD_CTL:  regRdata = ctlQ;
      RD_STAT: regRdata[ID_BIT] = idLevel;
      RD_INT:  regRdata[ID_BIT] = idFlag;
      default: regRdata = '0;
    endcase
  end

endmodule

// File: rtl/otg_id_ctl.sv
module otg_id_ctl
  import otg_id_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CTL_ADDR    = 'hE1,
  parameter int STAT_ADDR   = 'hE2,
  parameter int INT_ADDR    = 'hE3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idPin,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              irq,
  output logic              usbEnable,
  output logic              hostBank,
  output logic              clkFreeze,
  output logic              padEnable,
  output logic              coreClkEn
);

  busStrobe_t strobe;
  ctlReg_t    ctlQ;
  logic       idLevel;
  logic       idFlag;
  logic       flagClr;
  logic       idIe;

  otg_id_regctl #(
    .ADDR_W   (ADDR_W),
    .CTL_ADDR (CTL_ADDR),
    .STAT_ADDR(STAT_ADDR),
    .INT_ADDR (INT_ADDR)
  ) u_regctl (
    .regAddr (regAddr),
    .regWe   (regWe),
    .regWdata(regWdata),
    .strobe  (strobe)
  );

  otg_id_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .idPin   (idPin),
    .strobe  (strobe),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .ctlQ    (ctlQ),
    .idLevel (idLevel),
    .idFlag  (idFlag),
    .irq     (irq)
  );

  assign flagClr   = strobe.flagClr;
  assign idIe      = ctlQ.idIe;
  assign usbEnable = ctlQ.en;
  assign hostBank  = ctlQ.host;
  assign clkFreeze = ctlQ.frz;
  assign padEnable = ctlQ.pad;
  assign coreClkEn = ctlQ.en & ~ctlQ.frz;

endmodule

// File: rtl/otg_id_ctl_chk.sv
module otg_id_ctl_chk #(
  parameter int ADDR_W   = 8,
  parameter int CTL_ADDR = 'hE1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regRdata,
  input logic              irq,
  input logic              usbEnable,
  input logic              hostBank,
  input logic              clkFreeze,
  input logic              coreClkEn,
  input logic              idLevel,
  input logic              idFlag,
  input logic              flagClr,
  input logic              idIe
);

  a_r3_rsv_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(CTL_ADDR)) |-> (regRdata[3:2] == 2'b00));

  a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !usbEnable |-> (!hostBank && !clkFreeze));

  a_r5_clk_gate: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn |-> (usbEnable && !clkFreeze));

  a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
    (idLevel != $past(idLevel)) |=> idFlag);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (idFlag && !flagClr) |=> idFlag);

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (idFlag && idIe));

  a_r10_irq_raised: assert property (@(posedge clk) disable iff (!rstN)
    (idFlag && idIe) |-> irq);

endmodule

bind otg_id_ctl otg_id_ctl_chk #(
  .ADDR_W  (ADDR_W),
  .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regRdata (regRdata),
  .irq      (irq),
  .usbEnable(usbEnable),
  .hostBank (hostBank),
  .clkFreeze(clkFreeze),
  .coreClkEn(coreClkEn),
  .idLevel  (idLevel),
  .idFlag   (idFlag),
  .flagClr  (flagClr),
  .idIe     (idIe)
);

// File: tb/otg_id_ctl_tb.sv
`timescale 1ns/1ps
module otg_id_ctl_tb;

  localparam logic [7:0] A_CTL  = 8'hE1;
  localparam logic [7:0] A_STAT = 8'hE2;
  localparam logic [7:0] A_INT  = 8'hE3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       idPin = 1'b1;
  logic [7:0] regAddr = 8'h00;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       irq, usbEnable, hostBank, clkFreeze, padEnable, coreClkEn;

  int checkCount = 0;
  int failCount  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  otg_id_ctl u_dut (
    .clk(clk), .rstN(rstN), .idPin(idPin),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .usbEnable(usbEnable),
    .hostBank(hostBank), .clkFreeze(clkFreeze),
    .padEnable(padEnable), .coreClkEn(coreClkEn)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic idleEdges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] exp;
    logic       pinNow;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(A_CTL, rd);  chk("R1 ctl", rd, 8'h00);
    regRead(A_INT, rd);  chk("R1 int", rd, 8'h00);
    regRead(A_STAT, rd); chk("R1 stat", rd, 8'h02);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 R3 R4 R5 exhaustive control sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      d = v[7:0];
      exp = d & 8'hF3;
      if (!d[7]) exp[6:5] = 2'b00;
      regWrite(A_CTL, d);
      regRead(A_CTL, rd);
      chk("R2 R3 R4 ctl readback", rd, exp);
      chk("R5 outputs", {3'd0, usbEnable, hostBank, clkFreeze, padEnable, coreClkEn},
          {3'd0, exp[7], exp[6], exp[5], exp[4], exp[7] & ~exp[5]});
    end

    // R7 B-plug: pin held high never flags
    regWrite(A_CTL, 8'h02);
    regWrite(A_INT, 8'h00);
    idleEdges(40);
    regRead(A_INT, rd); chk("R7 steady high", rd, 8'h00);
    chk("R10 no irq", {7'd0, irq}, 8'h00);

    // R6 R7 R8 R10 R11 sweep over enable, interrupt enable, edge direction
    pinNow = 1'b1;
    for (int en = 0; en < 2; en++) begin
      for (int ie = 0; ie < 2; ie++) begin
        for (int dir = 0; dir < 2; dir++) begin
          regWrite(A_CTL, {en[0], 5'b00000, ie[0], 1'b0});
          regWrite(A_INT, 8'h00);
          pinNow = ~pinNow;
          idPin = pinNow;
          idleEdges(2);
          regRead(A_STAT, rd); chk("R6 status latency", rd, {6'd0, pinNow, 1'b0});
          regRead(A_INT, rd);  chk("R7 flag not early", rd, 8'h00);
          idleEdges(1);
          regRead(A_INT, rd);  chk("R7 R11 flag set", rd, 8'h02);
          chk("R10 R11 irq", {7'd0, irq}, {7'd0, ie[0]});
          regWrite(A_INT, 8'h02);
          regRead(A_INT, rd);  chk("R8 write one keeps", rd, 8'h02);
          idleEdges(5);
          regRead(A_INT, rd);  chk("R8 sticky", rd, 8'h02);
          regWrite(A_INT, 8'hFD);
          regRead(A_INT, rd);  chk("R8 clear", rd, 8'h00);
          chk("R10 irq after clear", {7'd0, irq}, 8'h00);
        end
      end
    end

    // R9 set wins over a clear landing on the same edge
    regWrite(A_CTL, 8'h02);
    regWrite(A_INT, 8'h00);
    pinNow = ~pinNow;
    idPin = pinNow;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    regAddr = A_INT; regWdata = 8'h00; regWe = 1'b1;
    @(posedge clk); @(negedge clk);
    regWe = 1'b0;
    regRead(A_INT, rd); chk("R9 set wins", rd, 8'h02);
    chk("R9 irq", {7'd0, irq}, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule